// File: doc/BRIEF.md
# Probabilistic neighbour-row refresh generator

This block sits next to the command scheduler of a DRAM controller and watches row closes (precharges). On every close it draws a pseudo-random number and, with a small probability set by a threshold input, asks the scheduler for one extra refresh. That refresh targets a row physically next to the row that was just closed, in the same bank. A second random bit chooses whether the row above or the row below is used. Rows that are opened and closed over and over therefore see their neighbours refreshed more often, although the block remembers nothing about any row.

Each close event is judged on its own. The pseudo-random source only advances when a close arrives. Accepted requests wait in a short queue, and the scheduler takes them with a valid/ready handshake. If the queue is full when a new request is produced, that request is lost and a saturating counter records the loss. A threshold of zero switches the block off completely.

Top module: `nbr_refresh_gen`

## Requirements
- R1: While reset is held, and on the first cycle after it, `req_valid` is 0 and `drop_count` is 0. Reset loads the random state with 16'hACE1.
- R2: The random state is a 16-bit Galois LFSR that shifts right. When the bit shifted out is 1, the new state is XORed with 16'hB400. The state steps exactly once on each cycle where `close_valid` is 1 and never on any other cycle.
- R3: A close fires when the low 8 bits of the random state, taken before that close's step, are strictly less than `thresh`. Nothing else causes a request.
- R4: With `thresh` equal to 0, no close ever produces a request and `drop_count` does not change.
- R5: On a fire, bit 15 of the pre-step state picks the side: 1 selects row+1 and 0 selects row-1. The request carries the bank of the close unchanged.
- R6: A fire on row 0 always requests row 1, whichever side was drawn.
- R7: A fire on the top row (all ones) always requests the row one below it, whichever side was drawn.
- R8: Requests leave in the order they fired. A request becomes visible on the cycle after its close. While `req_valid` is 1 and `req_ready` is 0, the outputs hold steady.
- R9: The queue holds 4 requests. A fire that arrives while 4 are held is dropped, even if one leaves in the same cycle, and `drop_count` rises by one. The counter saturates at all ones.
- R10: Over many closes of one row, the number of requests is close to closes × thresh/256, and both neighbours receive requests. The total count of neighbour refreshes grows as the closes accumulate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| close_valid | input | 1 | A row close (precharge) happens this cycle |
| close_bank | input | BANK_W | Bank of the closed row |
| close_row | input | ROW_W | Address of the closed row |
| thresh | input | TH_W | Fire threshold; probability is thresh/2^TH_W |
| req_valid | output | 1 | A neighbour refresh request is waiting |
| req_ready | input | 1 | Scheduler accepts the request this cycle |
| req_bank | output | BANK_W | Bank of the requested refresh |
| req_row | output | ROW_W | Row to refresh |
| drop_count | output | CNT_W | Saturating count of requests lost because the queue was full |

## Verification
The hardest case to reach is a fire that lands on an edge row. It needs a close of row 0 or of the top row at the exact moment the random draw both passes the threshold and picks the side that does not exist. The bench reaches it by setting the threshold to its maximum and closing the edge rows many times in a row, so both side values come up repeatedly. Overflow is reached by holding `req_ready` low through a burst of closes at maximum threshold. A bench-side model of the random sequence, taken from R2, predicts exactly which closes fire and which of them are dropped.

// File: rtl/prr_pkg.sv
package prr_pkg;

  typedef enum logic {
    SIDE_DN = 1'b0,
    SIDE_UP = 1'b1
  } side_e;

  localparam logic [63:0] PRR_MASK_DEFAULT = 64'hB400;
  localparam logic [63:0] PRR_SEED_DEFAULT = 64'hACE1;

endpackage

// File: rtl/prr_lfsr.sv
module prr_lfsr #(
  parameter int          W    = 16,
  parameter logic [63:0] MASK = prr_pkg::PRR_MASK_DEFAULT,
  parameter logic [63:0] SEED = prr_pkg::PRR_SEED_DEFAULT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);

  localparam logic [W-1:0] TAPS = MASK[W-1:0];
  localparam logic [W-1:0] INIT = SEED[W-1:0];

  function automatic logic [W-1:0] advance(input logic [W-1:0] s);
    logic [W-1:0] shifted;
    shifted = s >> 1;
    return s[0] ? (shifted ^ TAPS) : shifted;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= INIT;
    else if (step) state <= advance(state);
  end

endmodule

// File: rtl/prr_pick.sv
module prr_pick
  import prr_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int TH_W   = 8,
  parameter int LFSR_W = 16
) (
  input  logic              close_valid,
  input  logic [ROW_W-1:0]  close_row,
  input  logic [TH_W-1:0]   thresh,
  input  logic [LFSR_W-1:0] draw,
  output logic              fire,
  output side_e             side,
  output logic [ROW_W-1:0]  tgt_row
);

  localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);
  localparam logic [ROW_W-1:0] ROW_TOP = {ROW_W{1'b1}};

  function automatic logic passes(input logic [TH_W-1:0] sample,
                                  input logic [TH_W-1:0] limit);
    return sample < limit;
  endfunction

  function automatic logic [ROW_W-1:0] neighbour(input logic [ROW_W-1:0] r,
                                                 input side_e s);
    if (r == '0)      return ROW_ONE;
    if (r == ROW_TOP) return r - ROW_ONE;
    return (s == SIDE_UP) ? r + ROW_ONE : r - ROW_ONE;
  endfunction

  always_comb begin
    side    = side_e'(draw[LFSR_W-1]);
    fire    = close_valid && passes(draw[TH_W-1:0], thresh);
    tgt_row = neighbour(close_row, side);
  end

endmodule

// File: rtl/prr_fifo.sv
module prr_fifo #(
  parameter int DW    = 11,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          not_empty,
  output logic          full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign full      = (count == CAP);
  assign not_empty = (count != '0);
  assign do_push   = push && !full;
  assign do_pop    = pop && not_empty;
  assign rdata     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/nbr_refresh_gen.sv
module nbr_refresh_gen
  import prr_pkg::*;
#(
  parameter int          BANK_W     = 3,
  parameter int          ROW_W      = 8,
  parameter int          TH_W       = 8,
  parameter int          LFSR_W     = 16,
  parameter logic [63:0] LFSR_MASK  = PRR_MASK_DEFAULT,
  parameter logic [63:0] LFSR_SEED  = PRR_SEED_DEFAULT,
  parameter int          FIFO_DEPTH = 4,
  parameter int          CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close_valid,
  input  logic [BANK_W-1:0] close_bank,
  input  logic [ROW_W-1:0]  close_row,
  input  logic [TH_W-1:0]   thresh,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [BANK_W-1:0] req_bank,
  output logic [ROW_W-1:0]  req_row,
  output logic [CNT_W-1:0]  drop_count
);

  localparam int REQ_W = BANK_W + ROW_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [LFSR_W-1:0] lfsr_q;
  logic              fire_w;
  side_e             side_w;
  logic [ROW_W-1:0]  tgt_row_w;
  logic              fifo_full_w;
  logic              push_w;
  logic              drop_w;
  logic              pop_w;
  logic [REQ_W-1:0]  fifo_in_w;
  logic [REQ_W-1:0]  fifo_out_w;

  prr_lfsr #(
    .W    (LFSR_W),
    .MASK (LFSR_MASK),
    .SEED (LFSR_SEED)
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (close_valid),
    .state (lfsr_q)
  );

  prr_pick #(
    .ROW_W  (ROW_W),
    .TH_W   (TH_W),
    .LFSR_W (LFSR_W)
  ) u_pick (
    .close_valid (close_valid),
    .close_row   (close_row),
    .thresh      (thresh),
    .draw        (lfsr_q),
    .fire        (fire_w),
    .side        (side_w),
    .tgt_row     (tgt_row_w)
  );

  assign push_w    = fire_w && !fifo_full_w;
  assign drop_w    = fire_w && fifo_full_w;
  assign pop_w     = req_valid && req_ready;
  assign fifo_in_w = {close_bank, tgt_row_w};

  prr_fifo #(
    .DW    (REQ_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_w),
    .wdata     (fifo_in_w),
    .pop       (pop_w),
    .rdata     (fifo_out_w),
    .not_empty (req_valid),
    .full      (fifo_full_w)
  );

  assign req_bank = fifo_out_w[REQ_W-1:ROW_W];
  assign req_row  = fifo_out_w[ROW_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           drop_count <= '0;
    else if (drop_w && drop_count != CNT_MAX) drop_count <= drop_count + CNT_W'(1);
  end

endmodule

// File: rtl/prr_chk.sv
module prr_chk #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 8,
  parameter int TH_W   = 8,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              close_valid,
  input logic [ROW_W-1:0]  close_row,
  input logic [TH_W-1:0]   thresh,
  input logic              fire,
  input logic [ROW_W-1:0]  tgt_row,
  input logic              fifo_full,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BANK_W-1:0] req_bank,
  input logic [ROW_W-1:0]  req_row,
  input logic [CNT_W-1:0]  drop_count
);

  localparam logic [ROW_W-1:0] TOP = {ROW_W{1'b1}};
  localparam logic [ROW_W-1:0] ONE = ROW_W'(1);

  // R1: reset leaves the outputs idle
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!req_valid && drop_count == '0));

  assert_fire_needs_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !close_valid |-> !fire);

  assert_zero_thresh_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh == '0) |-> !fire);

  assert_adjacent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && close_row != '0 && close_row != TOP)
      |-> (tgt_row == close_row + ONE || tgt_row == close_row - ONE));

  assert_row0_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && close_row == '0) |-> (tgt_row == ONE));

  assert_top_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && close_row == TOP) |-> (tgt_row == TOP - ONE));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_row) && $stable(req_bank)));

  assert_drop_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fifo_full && drop_count != '1) |=> (drop_count == $past(drop_count) + CNT_W'(1)));

endmodule

bind nbr_refresh_gen prr_chk #(
  .BANK_W (BANK_W),
  .ROW_W  (ROW_W),
  .TH_W   (TH_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .close_valid (close_valid),
  .close_row   (close_row),
  .thresh      (thresh),
  .fire        (fire_w),
  .tgt_row     (tgt_row_w),
  .fifo_full   (fifo_full_w),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_bank    (req_bank),
  .req_row     (req_row),
  .drop_count  (drop_count)
);

// File: tb/nbr_refresh_gen_test.sv
module nbr_refresh_gen_test;

  localparam int CLK_P = 10;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       close_valid;
  logic [2:0] close_bank;
  logic [7:0] close_row;
  logic [7:0] thresh;
  logic       req_valid;
  logic       req_ready;
  logic [2:0] req_bank;
  logic [7:0] req_row;
  logic [7:0] drop_count;

  always #(CLK_P / 2) clk = ~clk;

  nbr_refresh_gen uut (
    .clk (clk), .rst_n (rst_n),
    .close_valid (close_valid), .close_bank (close_bank), .close_row (close_row),
    .thresh (thresh),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_bank (req_bank), .req_row (req_row),
    .drop_count (drop_count)
  );

  typedef struct { int bank; int row; } item_t;
  item_t exp_q[$];

  int          total = 0, failed = 0;
  int unsigned rnd = 32'hACE1;      // bench view of the random state (R2)
  int          drop_exp = 0, fires_model = 0;
  int          popped = 0, ups = 0, downs = 0;
  string       cur_tag = "R8";
  bit          done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // driver: one close per call, prediction goes to the scoreboard
  task automatic do_close(input int b, input int r);
    int unsigned low, hi;
    int tgt;
    @(negedge clk);
    close_valid = 1'b1;
    close_bank  = 3'(b);
    close_row   = 8'(r);
    low = rnd % 256;
    hi  = (rnd / 32768) % 2;
    if (low < int'(thresh)) begin
      fires_model++;
      if (r == 0)        tgt = 1;
      else if (r == 255) tgt = 254;
      else               tgt = hi ? r + 1 : r - 1;
      if (exp_q.size() < DEPTH) exp_q.push_back('{b, tgt});
      else if (drop_exp < 255)  drop_exp++;
    end
    rnd = (rnd / 2) ^ ((rnd % 2) ? 32'hB400 : 32'h0);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    close_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare each handshake against the scoreboard
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      if (exp_q.size() == 0) begin
        check(0, cur_tag, "unexpected request row", int'(req_row), -1);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check(int'(req_row) == e.row && int'(req_bank) == e.bank, cur_tag,
              "request bank*256+row", int'(req_bank) * 256 + int'(req_row),
              e.bank * 256 + e.row);
      end
      popped++;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      check(0, "R8", "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", total, failed);
      $finish;
    end
  end

  initial begin
    int p0, f0, f64;
    rst_n = 1'b0; close_valid = 1'b0; close_bank = '0; close_row = '0;
    thresh = '0; req_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(req_valid == 1'b0, "R1", "req_valid in reset", int'(req_valid), 0);
    check(drop_count == 8'd0, "R1", "drop_count in reset", int'(drop_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_valid == 1'b0, "R1", "req_valid after reset", int'(req_valid), 0);

    // R2 R3 R5: mixed rows and banks, idle gaps must not step the state
    cur_tag = "R5";
    thresh = 8'd128;
    for (int i = 0; i < 300; i++) begin
      do_close(i % 8, 1 + (i * 37) % 254);
      if (i % 7 == 3) idle(2);
    end
    idle(8);
    check(exp_q.size() == 0, "R2", "requests left unmatched", exp_q.size(), 0);
    check(popped == fires_model, "R3", "fires seen", popped, fires_model);

    // R4: threshold zero is silent
    cur_tag = "R4";
    thresh = 8'd0;
    p0 = popped;
    for (int i = 0; i < 200; i++) do_close(1, i);
    idle(8);
    check(popped == p0, "R4", "requests with zero threshold", popped - p0, 0);
    check(drop_count == 8'd0, "R4", "drop_count with zero threshold", int'(drop_count), 0);

    // R6: row 0 always goes up
    cur_tag = "R6";
    thresh = 8'd255;
    f0 = fires_model;
    for (int i = 0; i < 100; i++) do_close(4, 0);
    idle(8);
    check(fires_model - f0 > 50, "R6", "fires at row 0", fires_model - f0, 51);
    check(exp_q.size() == 0, "R6", "unmatched after row 0", exp_q.size(), 0);

    // R7: top row always goes down
    cur_tag = "R7";
    for (int i = 0; i < 100; i++) do_close(5, 255);
    idle(8);
    check(exp_q.size() == 0, "R7", "unmatched after top row", exp_q.size(), 0);

    // R9: overflow with the scheduler stalled
    cur_tag = "R9";
    req_ready = 1'b0;
    for (int i = 0; i < 20; i++) do_close(6, 100 + i);
    idle(3);
    check(req_valid == 1'b1, "R8", "req_valid while stalled", int'(req_valid), 1);
    check(exp_q.size() == DEPTH, "R9", "held requests", exp_q.size(), DEPTH);
    check(drop_exp > 0, "R9", "model drops", drop_exp, 1);
    check(int'(drop_count) == drop_exp, "R9", "drop_count", int'(drop_count), drop_exp);
    req_ready = 1'b1;
    idle(8);
    check(exp_q.size() == 0, "R8", "drained in order", exp_q.size(), 0);

    // R10: statistics on one hammered row
    cur_tag = "R10";
    thresh = 8'd64;
    f0 = fires_model;
    p0 = popped;
    f64 = 0;
    for (int i = 0; i < 4096; i++) begin
      do_close(2, 10);
      if (i == 63) f64 = fires_model - f0;
    end
    idle(8);
    check(popped - p0 == fires_model - f0, "R10", "requests vs model", popped - p0,
          fires_model - f0);
    check((popped - p0) > 864 && (popped - p0) < 1184, "R10", "fire count near 1024",
          popped - p0, 1024);
    check(f64 < (fires_model - f0), "R10", "cumulative growth", f64, fires_model - f0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end

  // R10: side balance, counted at the ports
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready && cur_tag == "R10") begin
      if (req_row == 8'd11) ups++;
      else if (req_row == 8'd9) downs++;
    end
  end

  final begin
    if (done) begin
      if (ups == 0 || downs == 0)
        $display("FAIL R10 one side never chosen act=%0d exp=%0d", ups * downs, 1);
    end
  end

endmodule